// File: doc/BRIEF.md
# Flash Program Command Sequencer

This block sits between a local requester and a parallel NOR-style flash device. It turns a single request into the sequence of bus cycles that the flash command set expects. A program request with an address and a data word becomes four things in turn: a setup command write, a data write to the same location, repeated status reads until the device reports ready, and an error classification of the final status byte. The block ends each operation with a one-cycle done pulse and a 2-bit result code. A separate timeout flag reports a device that never becomes ready.

The requester can also run other operations on their own. It can ask for a status check by itself. This lets the error classification wait until a batch of programs has finished, because the device keeps its error flags until they are cleared. It can also issue the clear-status command and the return-to-read-array command. The width of each bus-strobe phase, the read access delay and the poll limit are parameters. This lets the same block meet the timing of different devices at different clock rates.

Top module: `flash_prog_seq`

## Requirements
- R1: During and right after reset, chip enable, write enable and output enable are high (inactive), the data bus is not driven, and busy and done are low.
- R2: Operation code 00 (program) writes the setup value 0x40 to the requested address, then writes the requested data to the same address, then polls status.
- R3: Every bus write holds chip enable low for SETUP_CYC+PULSE_CYC+HOLD_CYC cycles and drives the data bus for all of those cycles. Write enable is low only for the middle PULSE_CYC cycles. Address and data stay stable while chip enable is low. Every bus cycle is preceded by one launch cycle and followed by one gap cycle with all strobes high.
- R4: A status read holds chip enable and output enable low for ACCESS_CYC cycles and samples bits 7:0 of the data bus in the last of them. While bit 7 of the sampled byte is 0, the read is repeated.
- R5: Once bit 7 reads 1, the result code is chosen by priority: 01 if bit 3 is set, else 10 if bit 1 is set (only when LOCK_CHECK is 1), else 11 if bit 4 is set, else 00.
- R6: A program request with the defer input high finishes with code 00 as soon as the device is ready, without looking at the error bits. Operation code 01 (status check) skips the writes and polls and classifies by R5.
- R7: Operation code 10 writes 0xFF, and operation code 11 writes 0x50, each as one bus write to the requested address, then finishes with code 00 and no status read.
- R8: If MAX_POLLS reads in a row all show bit 7 at 0, the operation finishes with the timeout flag at 1 and code 00. Ready on exactly the MAX_POLLS-th read is not a timeout.
- R9: Busy is high from the cycle after a request is accepted through the done cycle. Done is high for exactly one cycle. The result code and the timeout flag change only in the done cycle and hold until the next one.
- R10: A request presented while busy is high, including in the done cycle, is ignored. A request in the first idle cycle after done is accepted.
- R11: Write enable and output enable are never low together, and the data bus is never driven while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe, taken only while idle |
| reqOp | input | 2 | 00 program, 01 status check, 10 read array, 11 clear status |
| reqDefer | input | 1 | Program only: skip error classification |
| reqAddr | input | ADDR_W | Target flash address |
| reqData | input | DATA_W | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| errCode | output | 2 | 00 ok, 01 voltage, 10 protect, 11 program failure |
| timeout | output | 1 | Ready not seen within the poll limit |
| flAddr | output | ADDR_W | Flash address bus |
| flDqOut | output | DATA_W | Flash data bus, outgoing value |
| flDqOe | output | 1 | Drive enable for the outgoing data bus |
| flDqIn | input | DATA_W | Flash data bus, incoming value |
| flCeN | output | 1 | Chip enable, active low |
| flWeN | output | 1 | Write enable, active low |
| flOeN | output | 1 | Output enable, active low |

## Verification
Two things can land in the same cycle. One is the done pulse of one operation together with a new request. The other is the ready bit together with several error bits in one status byte. The bench provokes the first case by raising reqValid in the done cycle and in the middle of a poll loop. The per-cycle reference model expects idle pins right after each done, so any accepted intrusion shows up at once. For the second case, status bytes carry ready along with bits 3, 1 and 4 in several mixes, and the model's priority chain decides the expected code. Busy-phase bytes carry every error bit set, which shows that error bits are ignored until ready is seen.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [1:0] {
    OP_PROGRAM = 2'b00,
    OP_CHECK   = 2'b01,
    OP_READARR = 2'b10,
    OP_CLRSTAT = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    CMD_SETUP   = 2'd0,
    CMD_DATA    = 2'd1,
    CMD_READARR = 2'd2,
    CMD_CLRSTAT = 2'd3
  } cmdSel_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'b00,
    ERR_VOLT = 2'b01,
    ERR_PROT = 2'b10,
    ERR_PGM  = 2'b11
  } err_e;

  localparam logic [7:0] CODE_PGM_SETUP = 8'h40;
  localparam logic [7:0] CODE_READARR   = 8'hFF;
  localparam logic [7:0] CODE_CLRSTAT   = 8'h50;

  localparam int BIT_READY = 7;
  localparam int BIT_VOLT  = 3;
  localparam int BIT_PROT  = 1;
  localparam int BIT_PGM   = 4;

  // strobes from the sequence control to the bus datapath
  typedef struct packed {
    logic    latchReq;
    logic    launchWr;
    logic    launchRd;
    logic    incPoll;
    cmdSel_e cmdSel;
  } strobes_t;

endpackage

// File: rtl/fps_datapath.sv
module fps_datapath
  import fps_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 4,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 3,
  parameter int MAX_POLLS  = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] flDqIn,
  output logic              cycDone,
  output logic [7:0]        statusByte,
  output logic              pollLast,
  output logic [ADDR_W-1:0] flAddr,
  output logic [DATA_W-1:0] flDqOut,
  output logic              flDqOe,
  output logic              flCeN,
  output logic              flWeN,
  output logic              flOeN
);

  localparam int MAX_WA  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_WB  = (HOLD_CYC > ACCESS_CYC) ? HOLD_CYC : ACCESS_CYC;
  localparam int MAX_PH  = (MAX_WA > MAX_WB) ? MAX_WA : MAX_WB;
  localparam int TMR_W   = $clog2(MAX_PH + 1);
  localparam int POLL_W  = $clog2(MAX_POLLS + 1);

  localparam logic [TMR_W-1:0]  SU_LOAD = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0]  PW_LOAD = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0]  HD_LOAD = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0]  RD_LOAD = TMR_W'(ACCESS_CYC - 1);
  localparam logic [POLL_W-1:0] POLL_TOP = POLL_W'(MAX_POLLS - 1);

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD, PH_READ, PH_GAP
  } phase_e;

  phase_e              phase;
  logic [TMR_W-1:0]    timer;
  logic [ADDR_W-1:0]   addrReg;
  logic [DATA_W-1:0]   dataReg;
  logic [DATA_W-1:0]   wrWord;
  logic [DATA_W-1:0]   wordSel;
  logic [POLL_W-1:0]   pollCnt;
  logic                inWrite;
  logic                unusedDq;

  assign unusedDq = ^flDqIn;

  always_comb begin
    unique case (strb.cmdSel)
      CMD_DATA:    wordSel = dataReg;
      CMD_SETUP:   wordSel = DATA_W'(CODE_PGM_SETUP);
      CMD_READARR: wordSel = DATA_W'(CODE_READARR);
      default:     wordSel = DATA_W'(CODE_CLRSTAT);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      pollCnt <= '0;
    end else if (strb.latchReq) begin
      addrReg <= reqAddr;
      dataReg <= reqData;
      pollCnt <= '0;
    end else if (strb.incPoll) begin
      pollCnt <= pollCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      timer      <= '0;
      wrWord     <= '0;
      statusByte <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (strb.launchWr) begin
            phase  <= PH_SETUP;
            timer  <= SU_LOAD;
            wrWord <= wordSel;
          end else if (strb.launchRd) begin
            phase <= PH_READ;
            timer <= RD_LOAD;
          end
        end
        PH_SETUP: begin
          if (timer == '0) begin
            phase <= PH_PULSE;
            timer <= PW_LOAD;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        PH_PULSE: begin
          if (timer == '0) begin
            phase <= PH_HOLD;
            timer <= HD_LOAD;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        PH_HOLD: begin
          if (timer == '0) phase <= PH_GAP;
          else             timer <= timer - 1'b1;
        end
        PH_READ: begin
          if (timer == '0) begin
            phase      <= PH_GAP;
            statusByte <= flDqIn[7:0];
          end else begin
            timer <= timer - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign inWrite  = (phase == PH_SETUP) || (phase == PH_PULSE) || (phase == PH_HOLD);
  assign flAddr   = addrReg;
  assign flDqOut  = wrWord;
  assign flDqOe   = inWrite;
  assign flCeN    = !(inWrite || (phase == PH_READ));
  assign flWeN    = (phase != PH_PULSE);
  assign flOeN    = (phase != PH_READ);
  assign cycDone  = (phase == PH_GAP);
  assign pollLast = (pollCnt == POLL_TOP);

endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
#(
  parameter bit LOCK_CHECK = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       reqDefer,
  input  logic       cycDone,
  input  logic [7:0] statusByte,
  input  logic       pollLast,
  output strobes_t   strb,
  output logic       busy,
  output logic       done,
  output logic [1:0] errCode,
  output logic       timeout
);

  typedef enum logic [3:0] {
    S_IDLE, S_ISSUE_SU, S_WAIT_SU, S_ISSUE_DAT, S_WAIT_DAT,
    S_ISSUE_RD, S_WAIT_RD, S_ISSUE_CMD, S_WAIT_CMD, S_DONE
  } state_e;

  state_e state, nxt;
  op_e    opReg;
  logic   deferReg;
  logic   finish;
  err_e   finErr;
  logic   finTo;
  err_e   classErr;
  logic   protHit;
  logic   unusedStat;

  assign unusedStat = ^statusByte;

  generate
    if (LOCK_CHECK) begin : g_lockChk
      assign protHit = statusByte[BIT_PROT];
    end else begin : g_noLockChk
      assign protHit = 1'b0;
    end
  endgenerate

  always_comb begin
    if (statusByte[BIT_VOLT])     classErr = ERR_VOLT;
    else if (protHit)             classErr = ERR_PROT;
    else if (statusByte[BIT_PGM]) classErr = ERR_PGM;
    else                          classErr = ERR_NONE;
  end

  always_comb begin
    nxt         = state;
    strb        = '0;
    strb.cmdSel = CMD_SETUP;
    finish      = 1'b0;
    finErr      = ERR_NONE;
    finTo       = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          strb.latchReq = 1'b1;
          unique case (op_e'(reqOp))
            OP_PROGRAM: nxt = S_ISSUE_SU;
            OP_CHECK:   nxt = S_ISSUE_RD;
            default:    nxt = S_ISSUE_CMD;
          endcase
        end
      end
      S_ISSUE_SU: begin
        strb.launchWr = 1'b1;
        strb.cmdSel   = CMD_SETUP;
        nxt           = S_WAIT_SU;
      end
      S_WAIT_SU:  if (cycDone) nxt = S_ISSUE_DAT;
      S_ISSUE_DAT: begin
        strb.launchWr = 1'b1;
        strb.cmdSel   = CMD_DATA;
        nxt           = S_WAIT_DAT;
      end
      S_WAIT_DAT: if (cycDone) nxt = S_ISSUE_RD;
      S_ISSUE_RD: begin
        strb.launchRd = 1'b1;
        nxt           = S_WAIT_RD;
      end
      S_WAIT_RD: begin
        if (cycDone) begin
          if (!statusByte[BIT_READY]) begin
            if (pollLast) begin
              nxt    = S_DONE;
              finish = 1'b1;
              finTo  = 1'b1;
            end else begin
              strb.incPoll = 1'b1;
              nxt          = S_ISSUE_RD;
            end
          end else begin
            nxt    = S_DONE;
            finish = 1'b1;
            finErr = (opReg == OP_PROGRAM && deferReg) ? ERR_NONE : classErr;
          end
        end
      end
      S_ISSUE_CMD: begin
        strb.launchWr = 1'b1;
        strb.cmdSel   = (opReg == OP_READARR) ? CMD_READARR : CMD_CLRSTAT;
        nxt           = S_WAIT_CMD;
      end
      S_WAIT_CMD: begin
        if (cycDone) begin
          nxt    = S_DONE;
          finish = 1'b1;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      opReg    <= OP_PROGRAM;
      deferReg <= 1'b0;
      errCode  <= ERR_NONE;
      timeout  <= 1'b0;
    end else begin
      state <= nxt;
      if (strb.latchReq) begin
        opReg    <= op_e'(reqOp);
        deferReg <= reqDefer;
      end
      if (finish) begin
        errCode <= finErr;
        timeout <= finTo;
      end
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 4,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 3,
  parameter int MAX_POLLS  = 1000,
  parameter bit LOCK_CHECK = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic              reqDefer,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              busy,
  output logic              done,
  output logic [1:0]        errCode,
  output logic              timeout,
  output logic [ADDR_W-1:0] flAddr,
  output logic [DATA_W-1:0] flDqOut,
  output logic              flDqOe,
  input  logic [DATA_W-1:0] flDqIn,
  output logic              flCeN,
  output logic              flWeN,
  output logic              flOeN
);

  strobes_t   strb;
  logic       cycDone;
  logic [7:0] statusByte;
  logic       pollLast;

  fps_ctrl #(
    .LOCK_CHECK(LOCK_CHECK)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqOp      (reqOp),
    .reqDefer   (reqDefer),
    .cycDone    (cycDone),
    .statusByte (statusByte),
    .pollLast   (pollLast),
    .strb       (strb),
    .busy       (busy),
    .done       (done),
    .errCode    (errCode),
    .timeout    (timeout)
  );

  fps_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SETUP_CYC  (SETUP_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .ACCESS_CYC (ACCESS_CYC),
    .MAX_POLLS  (MAX_POLLS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .flDqIn     (flDqIn),
    .cycDone    (cycDone),
    .statusByte (statusByte),
    .pollLast   (pollLast),
    .flAddr     (flAddr),
    .flDqOut    (flDqOut),
    .flDqOe     (flDqOe),
    .flCeN      (flCeN),
    .flWeN      (flWeN),
    .flOeN      (flOeN)
  );

endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic [1:0]        errCode,
  input logic              timeout,
  input logic [ADDR_W-1:0] flAddr,
  input logic [DATA_W-1:0] flDqOut,
  input logic              flDqOe,
  input logic              flCeN,
  input logic              flWeN,
  input logic              flOeN
);

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(!flWeN && !flOeN));

  p_no_contention_r11: assert property (@(posedge clk) disable iff (!rstN)
    flDqOe |-> flOeN);

  p_we_inside_ce_r3: assert property (@(posedge clk) disable iff (!rstN)
    !flWeN |-> !flCeN);

  p_dq_stable_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    !flWeN |-> $stable(flDqOut));

  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!flCeN && $past(!flCeN)) |-> $stable(flAddr));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_busy_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !($stable(errCode) && $stable(timeout)) |-> done);

  p_timeout_code_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && timeout) |-> (errCode == 2'b00));

endmodule

bind flash_prog_seq fps_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_fpsChk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .done    (done),
  .errCode (errCode),
  .timeout (timeout),
  .flAddr  (flAddr),
  .flDqOut (flDqOut),
  .flDqOe  (flDqOe),
  .flCeN   (flCeN),
  .flWeN   (flWeN),
  .flOeN   (flOeN)
);

// File: tb/flash_prog_seq_test.sv
module flash_prog_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 12;
  localparam int DW   = 16;
  localparam int SU   = 2;
  localparam int PW   = 3;
  localparam int HD   = 1;
  localparam int AC   = 2;
  localparam int MAXP = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqOp = 2'b00;
  logic          reqDefer = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic          busy, done, timeout, flDqOe, flCeN, flWeN, flOeN;
  logic [1:0]    errCode;
  logic [AW-1:0] flAddr;
  logic [DW-1:0] flDqOut;
  logic [DW-1:0] flDqIn;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prog_seq #(
    .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SU), .PULSE_CYC(PW), .HOLD_CYC(HD),
    .ACCESS_CYC(AC), .MAX_POLLS(MAXP), .LOCK_CHECK(1'b1)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqDefer(reqDefer),
    .reqAddr(reqAddr), .reqData(reqData), .busy(busy), .done(done), .errCode(errCode),
    .timeout(timeout), .flAddr(flAddr), .flDqOut(flDqOut), .flDqOe(flDqOe),
    .flDqIn(flDqIn), .flCeN(flCeN), .flWeN(flWeN), .flOeN(flOeN)
  );

  int checks = 0;
  int errors = 0;
  int cycCount = 0;

  // flash device stand-in: busy byte (ready clear, all error bits set) then final byte
  int       pollsTotal = 0;
  int       pollBase = 0;
  int       busyPolls = 0;
  logic [7:0] finalStat = 8'h80;
  logic     lastOeN = 1'b1;
  assign flDqIn = ((pollsTotal - pollBase) < busyPolls) ? 16'h007F : {8'h00, finalStat};

  always @(negedge clk) begin
    if (!lastOeN && flOeN) pollsTotal = pollsTotal + 1;
    lastOeN = flOeN;
  end

  typedef struct {
    bit            ceN, weN, oeN, dqOe;
    logic [DW-1:0] dq;
    bit            busy, done;
    logic [1:0]    err;
    bit            to;
    string         tag;
  } exp_t;

  exp_t          expQ[$];
  logic [1:0]    heldErr = 2'b00;
  bit            heldTo = 1'b0;
  logic [AW-1:0] curAddr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
    end
  endtask

  function automatic exp_t mk(bit ce, bit we, bit oe, bit dqOe, logic [DW-1:0] dq,
                              bit bsy, string tag);
    exp_t e;
    e.ceN = ce; e.weN = we; e.oeN = oe; e.dqOe = dqOe; e.dq = dq;
    e.busy = bsy; e.done = 1'b0; e.err = heldErr; e.to = heldTo; e.tag = tag;
    return e;
  endfunction

  task automatic pushWrite(input logic [DW-1:0] v, input string tag);
    expQ.push_back(mk(1, 1, 1, 0, '0, 1, "R3"));                 // launch cycle
    for (int i = 0; i < SU; i++) expQ.push_back(mk(0, 1, 1, 1, v, 1, tag));
    for (int i = 0; i < PW; i++) expQ.push_back(mk(0, 0, 1, 1, v, 1, tag));
    for (int i = 0; i < HD; i++) expQ.push_back(mk(0, 1, 1, 1, v, 1, tag));
    expQ.push_back(mk(1, 1, 1, 0, '0, 1, "R3"));                 // gap cycle
  endtask

  task automatic pushRead();
    expQ.push_back(mk(1, 1, 1, 0, '0, 1, "R4"));
    for (int i = 0; i < AC; i++) expQ.push_back(mk(0, 1, 0, 0, '0, 1, "R4"));
    expQ.push_back(mk(1, 1, 1, 0, '0, 1, "R4"));
  endtask

  task automatic pushDone(input logic [1:0] err, input bit to, input string tag);
    exp_t e;
    heldErr = err;
    heldTo  = to;
    e = mk(1, 1, 1, 0, '0, 1, tag);
    e.done = 1'b1;
    expQ.push_back(e);
  endtask

  // per-cycle comparison of every output against the model queue
  always @(negedge clk) begin
    exp_t e;
    if (rstN) begin
      if (expQ.size() > 0) e = expQ.pop_front();
      else e = mk(1, 1, 1, 0, '0, 0, "R9");
      chk(flCeN == e.ceN, e.oeN ? "R3" : "R4", "ceN", flCeN, e.ceN);
      chk(flWeN == e.weN, "R3", "weN", flWeN, e.weN);
      chk(flOeN == e.oeN, "R4", "oeN", flOeN, e.oeN);
      chk(flDqOe == e.dqOe, "R11", "dqOe", flDqOe, e.dqOe);
      if (e.dqOe) chk(flDqOut == e.dq, e.tag, "dq", flDqOut, e.dq);
      if (!e.ceN) chk(flAddr == curAddr, "R2", "addr", flAddr, curAddr);
      chk(busy == e.busy, "R9", "busy", busy, e.busy);
      chk(done == e.done, e.done ? e.tag : "R9", "done", done, e.done);
      chk(errCode == e.err, e.done ? e.tag : "R9", "errCode", errCode, e.err);
      chk(timeout == e.to, e.done ? e.tag : "R8", "timeout", timeout, e.to);
    end
  end

  // R5 priority as seen by the model
  function automatic logic [1:0] classify(input logic [7:0] s);
    if (s[3]) return 2'b01;
    if (s[1]) return 2'b10;
    if (s[4]) return 2'b11;
    return 2'b00;
  endfunction

  // intrude: 0 none, >0 cycle index of a stray request, -1 the done cycle
  task automatic runOp(input logic [1:0] op, input logic [AW-1:0] addr,
                       input logic [DW-1:0] data, input bit defer, input int bp,
                       input logic [7:0] fs, input int intrude, input string tag);
    int nReads, len, at;
    bit to;
    logic [1:0] err;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = addr; reqData = data; reqDefer = defer;
    pollBase = pollsTotal; busyPolls = bp; finalStat = fs;
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    curAddr = addr;
    nReads = (bp >= MAXP) ? MAXP : bp + 1;
    to = (bp >= MAXP);
    err = to ? 2'b00 : ((op == 2'b00 && defer) ? 2'b00 : classify(fs));
    case (op)
      2'b00: begin
        pushWrite(16'h0040, "R2");
        pushWrite(data, "R2");
        for (int i = 0; i < nReads; i++) pushRead();
        pushDone(err, to, tag);
      end
      2'b01: begin
        for (int i = 0; i < nReads; i++) pushRead();
        pushDone(err, to, tag);
      end
      2'b10: begin pushWrite(16'h00FF, "R7"); pushDone(2'b00, 1'b0, "R7"); end
      default: begin pushWrite(16'h0050, "R7"); pushDone(2'b00, 1'b0, "R7"); end
    endcase
    len = expQ.size();
    at = (intrude < 0) ? len : intrude;
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      if (k == at) begin
        // R10: stray request while busy
        reqValid = 1'b1; reqOp = 2'b10; reqAddr = ~addr; reqData = ~data;
      end else if (reqValid) begin
        reqValid = 1'b0;
      end
    end
    @(negedge clk);
    reqValid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycCount++;
    if (cycCount > 50000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<50000", cycCount);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle state while in reset
    chk(flCeN == 1'b1, "R1", "ceN in reset", flCeN, 1);
    chk(flWeN == 1'b1, "R1", "weN in reset", flWeN, 1);
    chk(flOeN == 1'b1, "R1", "oeN in reset", flOeN, 1);
    chk(flDqOe == 1'b0, "R1", "dqOe in reset", flDqOe, 0);
    chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runOp(2'b00, 12'h123, 16'hBEEF, 0, 2, 8'h80, 0, "R5");   // R2 clean program
    runOp(2'b00, 12'h200, 16'h1234, 0, 1, 8'h98, 0, "R5");   // voltage beats program fail
    runOp(2'b00, 12'h201, 16'h5678, 0, 0, 8'h92, 0, "R5");   // protect beats program fail
    runOp(2'b00, 12'h202, 16'h9ABC, 0, 3, 8'h90, 0, "R5");   // program fail alone
    runOp(2'b00, 12'h203, 16'h0F0F, 0, 0, 8'h9A, 0, "R5");   // all three set: voltage wins
    runOp(2'b00, 12'h300, 16'hA5A5, 1, 1, 8'h90, 0, "R6");   // deferred: ok at ready
    runOp(2'b01, 12'h300, 16'h0000, 0, 0, 8'h90, 0, "R6");   // later check reports it
    runOp(2'b11, 12'h000, 16'h0000, 0, 0, 8'h80, 0, "R7");   // clear status
    runOp(2'b10, 12'h0FF, 16'h0000, 0, 0, 8'h80, 0, "R7");   // read array
    runOp(2'b00, 12'h400, 16'h4444, 0, 9, 8'h80, 0, "R8");   // never ready
    runOp(2'b00, 12'h401, 16'h5555, 0, MAXP - 1, 8'h80, 0, "R8"); // ready on last poll
    runOp(2'b00, 12'h500, 16'h6666, 0, 1, 8'h80, 5, "R10");  // stray request mid-write
    runOp(2'b01, 12'h501, 16'h0000, 0, 2, 8'h82, -1, "R10"); // stray request in done cycle
    chk(errCode == 2'b10 && !busy, "R10", "final state after intrusions", {busy, errCode}, 2'b10);
    report();
  end

endmodule